// File: doc/BRIEF.md
# Nonvolatile Memory Erase/Program Sequencer

This block sits in front of a word-addressed nonvolatile storage array. It serves a single request/acknowledge bus with two address windows. The data window reads and programs aligned 32-bit words. The configuration window holds a status word and a control word. Writing a one-based sector number into the erase field of the control word starts a sector erase. Writing into the data window programs one word. Programming can only clear bits, and a read-back then confirms whether the stored word matches what was written.

Each sector has its own protect bit in the control word, and that bit gates both erase and program. The status word reports a two-bit activity code, sticky success flags for reads, writes and erases, and a copy of the protect bits. Software is expected to follow this sequence:

1. Clear the protect bits.
2. Erase each sector in turn, polling the status word until the erase finishes.
3. Program the image word by word, checking the write flag after each word.
4. Set the erase field back to "none" and protect every sector again.

The storage is a behavioural array inside the project, and its erase, program and read latencies are parameters.

Top module: `nvm_ctrl`

## Requirements
- R1: After reset the status word reads 0x000001E0: activity code 0, the three success flags clear, and status bits [8:5] show all four protect bits set. The control word reads 0x07F00000: erase field [22:20] is 7 and protect bits [26:23] are all set.
- R2: The configuration window is selected with `cfg_sel`=1, and `addr[0]` picks the word (0 = status, 1 = control). Configuration reads are acknowledged one cycle after the request, even while an operation runs. The control word keeps only bits [26:20]. Every other bit, including bit 0 (reserved for a page-erase request), reads 0 and has no effect.
- R3: Writing n = 1..4 into control bits [22:20] erases sector n-1 if its protect bit is clear. Status bits [1:0] read 1 for ERASE_CYCLES cycles. After that, every word of the sector reads 0xFFFFFFFF, status bit 4 is set, and the other sectors keep their contents.
- R4: Erase field values 0, 5, 6 and 7 start nothing: the activity code stays 0 and the array is unchanged.
- R5: Control bit 23+s protects sector s, and status bit 5+s mirrors it.
- R6: An erase aimed at a protected sector leaves the array unchanged, clears status bit 4, and leaves the activity code at 0.
- R7: A data write to an unprotected word (sector = word address / SECTOR_WORDS) stores the old word AND the written data. Status bit 3 is set if the read-back equals the written data and cleared otherwise. The acknowledge comes PROG_CYCLES+2 cycles after the request, and the activity code is 2 during the operation.
- R8: A data write to a protected sector leaves the word unchanged, clears status bit 3, and is acknowledged after one cycle.
- R9: A data read returns the stored word and sets status bit 2. The acknowledge comes READ_CYCLES+1 cycles after the request, and the activity code is 3 while the read is pending.
- R10: A data access or configuration write made while an operation is running gets no acknowledge until that operation ends; only then does the new access start.
- R11: Every access receives exactly one acknowledge, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request, held until `ack` |
| we | input | 1 | 1 = write, 0 = read |
| cfg_sel | input | 1 | 1 = configuration window, 0 = data window |
| addr | input | $clog2(SECTORS*SECTOR_WORDS) (6) | Word address; in the configuration window only bit 0 is used |
| wdata | input | 32 | Write data |
| ack | output | 1 | One-cycle access acknowledge |
| rdata | output | 32 | Read data, valid while `ack` is high |

## Verification
The hardest situations to reach from the ports are an access arriving during an erase and the length of the busy window itself. Neither is visible unless the bus is driven in the middle of an erase.

The bench starts an erase and at once issues a data read or program. It checks that the acknowledge is delayed by exactly the remaining erase time plus the new operation's own latency. In a separate run it polls the status word back to back and counts how many polls see the erase code.

Programming that tries to set bits is produced on purpose by writing over already-programmed words. The bench predicts the AND result and the write flag from its own model of the array.

// File: rtl/nvm_pkg.sv
package nvm_pkg;
   localparam int DATA_W    = 32;
   localparam int ER_W      = 3;
   localparam int SR_RD_OK  = 2;
   localparam int SR_WR_OK  = 3;
   localparam int SR_ER_OK  = 4;
   localparam int SR_WP_LSB = 5;
   localparam int CR_ER_LSB = 20;
   localparam int CR_WP_LSB = 23;
   localparam logic [ER_W-1:0] ER_NONE = 3'd7;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ERASE,
      ST_PROG,
      ST_VERIFY,
      ST_READ
   } nvm_state_e;

   function automatic logic [1:0] busy_code(nvm_state_e s);
      case (s)
         ST_ERASE:           return 2'd1;
         ST_PROG, ST_VERIFY: return 2'd2;
         ST_READ:            return 2'd3;
         default:            return 2'd0;
      endcase
   endfunction
endpackage

// File: rtl/nvm_timer.sv
module nvm_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         last
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)                      cnt <= '0;
      else if (load)                cnt <= load_val;
      else if (run && cnt != '0)    cnt <= cnt - W'(1);
   end

   assign last = run && (cnt == W'(1));
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
   parameter int SECTORS      = 4,
   parameter int SECTOR_WORDS = 16,
   localparam int WORDS = SECTORS * SECTOR_WORDS,
   localparam int AW    = $clog2(WORDS),
   localparam int SEC_W = $clog2(SECTORS)
) (
   input  logic             clk,
   input  logic             er_en,
   input  logic [SEC_W-1:0] er_sec,
   input  logic             pg_en,
   input  logic [AW-1:0]    addr,
   input  logic [31:0]      pg_data,
   output logic [31:0]      rd_data
);
   logic [31:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (er_en) begin
         for (int i = 0; i < WORDS; i++) begin
            if (i / SECTOR_WORDS == int'(er_sec)) mem[i] <= '1;
         end
      end else if (pg_en) begin
         mem[addr] <= mem[addr] & pg_data;
      end
   end

   assign rd_data = mem[addr];
endmodule

// File: rtl/nvm_seq.sv
module nvm_seq
   import nvm_pkg::*;
#(
   parameter int SECTORS      = 4,
   parameter int SECTOR_WORDS = 16,
   parameter int ERASE_CYCLES = 8,
   parameter int PROG_CYCLES  = 3,
   parameter int READ_CYCLES  = 1,
   localparam int WORDS  = SECTORS * SECTOR_WORDS,
   localparam int AW     = $clog2(WORDS),
   localparam int OFF_W  = $clog2(SECTOR_WORDS),
   localparam int SEC_W  = $clog2(SECTORS),
   localparam int MAX_EP = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES,
   localparam int MAX_C  = (MAX_EP > READ_CYCLES) ? MAX_EP : READ_CYCLES,
   localparam int TW     = $clog2(MAX_C + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req,
   input  logic              we,
   input  logic              cfg_sel,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              ack,
   output logic [DATA_W-1:0] rdata,
   output logic              er_en,
   output logic [SEC_W-1:0]  er_sec,
   output logic              pg_en,
   output logic [AW-1:0]     mem_addr,
   output logic [DATA_W-1:0] pg_data,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] sr_o,
   output logic [DATA_W-1:0] cr_o
);
   nvm_state_e        state;
   logic [SECTORS-1:0] wp;
   logic [ER_W-1:0]   er_fld;
   logic              ok_rd, ok_wr, ok_er;
   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [SEC_W-1:0]  er_sec_q;

   logic              take, cfg_rd, acc, a_prot, er_valid;
   logic              start_er, start_pg, start_rd, tm_load, tm_last, run;
   logic [SEC_W-1:0]  a_sec, er_tgt;
   logic [ER_W-1:0]   new_fld;
   logic [SECTORS-1:0] new_wp;
   logic [TW-1:0]     tm_val;

   always_comb begin
      sr_o = '0;
      sr_o[1:0]                  = busy_code(state);
      sr_o[SR_RD_OK]             = ok_rd;
      sr_o[SR_WR_OK]             = ok_wr;
      sr_o[SR_ER_OK]             = ok_er;
      sr_o[SR_WP_LSB +: SECTORS] = wp;
      cr_o = '0;
      cr_o[CR_ER_LSB +: ER_W]    = er_fld;
      cr_o[CR_WP_LSB +: SECTORS] = wp;
   end

   always_comb begin
      take     = req && !ack;
      cfg_rd   = take && cfg_sel && !we;
      acc      = take && (state == ST_IDLE) && !cfg_rd;
      a_sec    = addr[AW-1:OFF_W];
      a_prot   = (int'(a_sec) >= SECTORS) || wp[a_sec];
      new_fld  = wdata[CR_ER_LSB +: ER_W];
      new_wp   = wdata[CR_WP_LSB +: SECTORS];
      er_valid = (new_fld != '0) && (int'(new_fld) <= SECTORS);
      er_tgt   = SEC_W'(new_fld - ER_W'(1));
      start_er = acc && cfg_sel && addr[0] && er_valid && !new_wp[er_tgt];
      start_pg = acc && !cfg_sel && we && !a_prot;
      start_rd = acc && !cfg_sel && !we;
      tm_load  = start_er || start_pg || start_rd;
      tm_val   = start_er ? TW'(ERASE_CYCLES) :
                 start_pg ? TW'(PROG_CYCLES)  : TW'(READ_CYCLES);
      run      = (state == ST_ERASE) || (state == ST_PROG) || (state == ST_READ);
   end

   nvm_timer #(.W(TW)) tmr_i (
      .clk      (clk),
      .rst      (rst),
      .load     (tm_load),
      .load_val (tm_val),
      .run      (run),
      .last     (tm_last)
   );

   always_ff @(posedge clk) begin
      ack <= 1'b0;
      if (rst) begin
         state    <= ST_IDLE;
         wp       <= '1;
         er_fld   <= ER_NONE;
         ok_rd    <= 1'b0;
         ok_wr    <= 1'b0;
         ok_er    <= 1'b0;
         addr_q   <= '0;
         wdata_q  <= '0;
         er_sec_q <= '0;
         rdata    <= '0;
      end else begin
         if (cfg_rd) begin
            ack   <= 1'b1;
            rdata <= addr[0] ? cr_o : sr_o;
         end
         if (acc) begin
            addr_q  <= addr;
            wdata_q <= wdata;
            rdata   <= '0;
            if (cfg_sel) begin
               ack <= 1'b1;
               if (addr[0]) begin
                  wp     <= new_wp;
                  er_fld <= new_fld;
                  if (start_er) begin
                     state    <= ST_ERASE;
                     er_sec_q <= er_tgt;
                  end else if (er_valid) begin
                     ok_er <= 1'b0;
                  end
               end
            end else if (we) begin
               if (start_pg) state <= ST_PROG;
               else begin
                  ok_wr <= 1'b0;
                  ack   <= 1'b1;
               end
            end else begin
               state <= ST_READ;
            end
         end
         case (state)
            ST_ERASE: if (tm_last) begin
               state <= ST_IDLE;
               ok_er <= 1'b1;
            end
            ST_PROG: if (tm_last) state <= ST_VERIFY;
            ST_VERIFY: begin
               ok_wr <= (mem_rdata == wdata_q);
               ack   <= 1'b1;
               state <= ST_IDLE;
            end
            ST_READ: if (tm_last) begin
               rdata <= mem_rdata;
               ok_rd <= 1'b1;
               ack   <= 1'b1;
               state <= ST_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign er_en    = (state == ST_ERASE) && tm_last;
   assign er_sec   = er_sec_q;
   assign pg_en    = (state == ST_PROG) && tm_last;
   assign mem_addr = addr_q;
   assign pg_data  = wdata_q;
endmodule

// File: rtl/nvm_ctrl.sv
module nvm_ctrl
   import nvm_pkg::*;
#(
   parameter int SECTORS      = 4,
   parameter int SECTOR_WORDS = 16,
   parameter int ERASE_CYCLES = 8,
   parameter int PROG_CYCLES  = 3,
   parameter int READ_CYCLES  = 1,
   localparam int AW    = $clog2(SECTORS * SECTOR_WORDS),
   localparam int SEC_W = $clog2(SECTORS)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          req,
   input  logic          we,
   input  logic          cfg_sel,
   input  logic [AW-1:0] addr,
   input  logic [31:0]   wdata,
   output logic          ack,
   output logic [31:0]   rdata
);
   generate
      if (SECTORS < 2 || SECTORS > 6) begin : g_bad_sectors
         $error("SECTORS must lie in 2..6 to fit the erase field");
      end
      if (SECTOR_WORDS < 2 || (SECTOR_WORDS & (SECTOR_WORDS - 1)) != 0) begin : g_bad_words
         $error("SECTOR_WORDS must be a power of two, at least 2");
      end
      if (ERASE_CYCLES < 1 || PROG_CYCLES < 1 || READ_CYCLES < 1) begin : g_bad_lat
         $error("all latencies must be at least one cycle");
      end
   endgenerate

   logic              er_en, pg_en;
   logic [SEC_W-1:0]  er_sec;
   logic [AW-1:0]     mem_addr;
   logic [31:0]       pg_data, mem_rdata, sr_w, cr_w;

   nvm_seq #(
      .SECTORS      (SECTORS),
      .SECTOR_WORDS (SECTOR_WORDS),
      .ERASE_CYCLES (ERASE_CYCLES),
      .PROG_CYCLES  (PROG_CYCLES),
      .READ_CYCLES  (READ_CYCLES)
   ) seq_i (
      .clk       (clk),
      .rst       (rst),
      .req       (req),
      .we        (we),
      .cfg_sel   (cfg_sel),
      .addr      (addr),
      .wdata     (wdata),
      .ack       (ack),
      .rdata     (rdata),
      .er_en     (er_en),
      .er_sec    (er_sec),
      .pg_en     (pg_en),
      .mem_addr  (mem_addr),
      .pg_data   (pg_data),
      .mem_rdata (mem_rdata),
      .sr_o      (sr_w),
      .cr_o      (cr_w)
   );

   nvm_array #(
      .SECTORS      (SECTORS),
      .SECTOR_WORDS (SECTOR_WORDS)
   ) array_i (
      .clk     (clk),
      .er_en   (er_en),
      .er_sec  (er_sec),
      .pg_en   (pg_en),
      .addr    (mem_addr),
      .pg_data (pg_data),
      .rd_data (mem_rdata)
   );
endmodule

module nvm_ctrl_chk
   import nvm_pkg::*;
#(
   parameter int SECTORS = 4
) (
   input logic        clk,
   input logic        rst,
   input logic        req,
   input logic        we,
   input logic        cfg_sel,
   input logic        addr_lsb,
   input logic [31:0] wdata,
   input logic        ack,
   input logic [31:0] sr,
   input logic [31:0] cr
);
   localparam logic [31:0] RST_SR = 32'(((1 << SECTORS) - 1) << SR_WP_LSB);
   localparam logic [31:0] RST_CR = 32'((((1 << SECTORS) - 1) << CR_WP_LSB) | (7 << CR_ER_LSB));

   logic [ER_W-1:0] fld;
   logic            prot_er_req;

   always_comb begin
      fld = wdata[CR_ER_LSB +: ER_W];
      prot_er_req = 1'b0;
      if (req && !ack && cfg_sel && we && addr_lsb && sr[1:0] == 2'd0 &&
          fld != '0 && int'(fld) <= SECTORS)
         prot_er_req = wdata[CR_WP_LSB + int'(fld) - 1];
   end

   // R1
   reset_val_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (sr == RST_SR && cr == RST_CR));
   // R11
   ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      ack |=> !ack);
   // R10
   holdoff_chk: assert property (@(posedge clk) disable iff (rst)
      (sr[1:0] == 2'd1 && req && (we || !cfg_sel)) |=> !ack);
   // R3
   er_flag_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sr[SR_ER_OK]) |-> $past(sr[1:0]) == 2'd1);
   // R7
   wr_flag_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sr[SR_WR_OK]) |-> $past(sr[1:0]) == 2'd2);
   // R9
   rd_flag_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sr[SR_RD_OK]) |-> $past(sr[1:0]) == 2'd3);
   // R6
   prot_er_chk: assert property (@(posedge clk) disable iff (rst)
      prot_er_req |=> (sr[1:0] == 2'd0 && !sr[SR_ER_OK]));
endmodule

bind nvm_ctrl nvm_ctrl_chk #(.SECTORS(SECTORS)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .req      (req),
   .we       (we),
   .cfg_sel  (cfg_sel),
   .addr_lsb (addr[0]),
   .wdata    (wdata),
   .ack      (ack),
   .sr       (sr_w),
   .cr       (cr_w)
);

// File: tb/nvm_ctrl_tb_top.sv
`timescale 1ns/1ps
module nvm_ctrl_tb_top;
   localparam int SECT = 4;
   localparam int SW   = 16;
   localparam int EC   = 8;
   localparam int PC   = 3;
   localparam int RC   = 1;
   localparam int NW   = SECT * SW;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req = 1'b0, we = 1'b0, cfg_sel = 1'b0;
   logic [5:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic        ack;
   logic [31:0] rdata;

   int n_chk = 0, n_fail = 0, cycles = 0;
   logic [31:0] model [NW];

   always #10 clk = ~clk;

   nvm_ctrl #(.SECTORS(SECT), .SECTOR_WORDS(SW), .ERASE_CYCLES(EC),
              .PROG_CYCLES(PC), .READ_CYCLES(RC)) dut_i (
      .clk(clk), .rst(rst), .req(req), .we(we), .cfg_sel(cfg_sel),
      .addr(addr), .wdata(wdata), .ack(ack), .rdata(rdata));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // called at a negedge, returns at a negedge one idle cycle after ack
   task automatic bus(input logic c, input logic w, input logic [5:0] a,
                      input logic [31:0] d, output logic [31:0] q, output int lat);
      req = 1'b1; cfg_sel = c; we = w; addr = a; wdata = d; lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!ack && lat < 1000);
      q = rdata;
      req = 1'b0;
      @(negedge clk);
      n_chk++;
      if (ack !== 1'b0) begin
         n_fail++;
         $display("FAIL R11: got ack %b expected 0 after one cycle", ack);
      end
   endtask

   function automatic logic [31:0] pat(input int w, input int r);
      return 32'(w * 32'h9E3779B9) ^ 32'(r * 32'h5A5AC3C3) ^ 32'h0F0F1234;
   endfunction

   logic [31:0] q, sr;
   int lat, busy_n;

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);

      // R1 reset state
      bus(1, 0, 6'd0, 0, q, lat); chk("R1 sr", q, 32'h000001E0);
      bus(1, 0, 6'd1, 0, q, lat); chk("R1 cr", q, 32'h07F00000);
      chk("R2 cfg read latency", 32'(lat), 32'd1);

      // R2 reserved bits including page-erase bit 0
      bus(1, 1, 6'd1, 32'h07FFFFFF, q, lat);
      bus(1, 0, 6'd1, 0, q, lat); chk("R2 cr masked", q, 32'h07F00000);
      bus(1, 0, 6'd0, 0, q, lat); chk("R2 sr idle", q, 32'h000001E0);

      // R5 unprotect, mirror
      bus(1, 1, 6'd1, 32'h00700000, q, lat);
      bus(1, 0, 6'd0, 0, q, lat); chk("R5 sr mirror clear", q, 32'h00000000);

      // R3 erase every sector, count busy polls
      for (int s = 0; s < SECT; s++) begin
         bus(1, 1, 6'd1, 32'((s + 1) << 20), q, lat);
         busy_n = 0;
         do begin
            bus(1, 0, 6'd0, 0, sr, lat);
            if (sr[1:0] == 2'd1) busy_n++;
         end while (sr[1:0] == 2'd1 && busy_n < 100);
         chk("R3 erase busy polls", 32'(busy_n), 32'((EC - 2) / 2 + 1));
         chk("R3 sr after erase", sr, 32'h00000010);
         for (int w = s * SW; w < (s + 1) * SW; w++) model[w] = '1;
      end

      // R9 read sweep
      for (int w = 0; w < NW; w++) begin
         bus(0, 0, 6'(w), 0, q, lat);
         chk("R9 erased word", q, model[w]);
         chk("R9 read latency", 32'(lat), 32'(RC + 1));
      end
      bus(1, 0, 6'd0, 0, q, lat); chk("R9 read flag", q, 32'h00000014);

      // R7 program sweep on erased words
      for (int w = 0; w < NW; w++) begin
         bus(0, 1, 6'(w), pat(w, 0), q, lat);
         chk("R7 program latency", 32'(lat), 32'(PC + 2));
         model[w] = pat(w, 0);
         bus(1, 0, 6'd0, 0, sr, lat); chk("R7 write flag set", 32'(sr[3]), 32'd1);
         bus(0, 0, 6'(w), 0, q, lat); chk("R7 readback", q, model[w]);
      end

      // R7 over-programming: odd words try to set bits, even words only clear
      for (int w = 0; w < NW; w++) begin
         logic [31:0] d, e;
         d = (w % 2 == 1) ? pat(w, 1) : (model[w] & pat(w, 1));
         e = model[w] & d;
         bus(0, 1, 6'(w), d, q, lat);
         model[w] = e;
         bus(1, 0, 6'd0, 0, sr, lat);
         chk("R7 write flag", 32'(sr[3]), 32'(e == d));
         bus(0, 0, 6'(w), 0, q, lat); chk("R7 AND result", q, e);
      end

      // R5 protect sector 2
      bus(1, 1, 6'd1, 32'h02700000, q, lat);
      bus(1, 0, 6'd0, 0, sr, lat); chk("R5 protect mirror", 32'(sr[8:5]), 32'h4);

      // R8 program into protected sector
      bus(0, 1, 6'd32, 32'h0, q, lat);
      chk("R8 protected latency", 32'(lat), 32'd1);
      bus(1, 0, 6'd0, 0, sr, lat); chk("R8 write flag clear", 32'(sr[3]), 32'd0);
      bus(0, 0, 6'd32, 0, q, lat); chk("R8 word unchanged", q, model[32]);

      // R6 protected erase clears the erase flag (set earlier)
      bus(1, 1, 6'd1, 32'h02300000, q, lat);
      bus(1, 0, 6'd0, 0, sr, lat);
      chk("R6 idle", 32'(sr[1:0]), 32'd0);
      chk("R6 erase flag cleared", 32'(sr[4]), 32'd0);
      bus(0, 0, 6'd40, 0, q, lat); chk("R6 word unchanged", q, model[40]);

      // R4 field values that start nothing
      for (int f = 0; f < 8; f++) begin
         if (f == 0 || f > SECT) begin
            bus(1, 1, 6'd1, 32'h02000000 | 32'(f << 20), q, lat);
            bus(1, 0, 6'd0, 0, sr, lat); chk("R4 no busy", 32'(sr[1:0]), 32'd0);
            bus(0, 0, 6'(f * 7), 0, q, lat); chk("R4 word unchanged", q, model[f * 7]);
         end
      end

      // R10 read held off during erase of sector 0
      bus(1, 1, 6'd1, 32'h02100000, q, lat);
      bus(0, 0, 6'd5, 0, q, lat);
      chk("R10 held read latency", 32'(lat), 32'(EC + RC));
      chk("R10 read after erase", q, 32'hFFFFFFFF);
      for (int w = 0; w < SW; w++) model[w] = '1;

      // R10 program held off during erase of sector 1
      bus(1, 1, 6'd1, 32'h02200000, q, lat);
      bus(0, 1, 6'd16, 32'h12345678, q, lat);
      chk("R10 held program latency", 32'(lat), 32'(EC + PC + 1));
      bus(0, 0, 6'd16, 0, q, lat); chk("R10 program after erase", q, 32'h12345678);
      bus(0, 0, 6'd17, 0, q, lat); chk("R3 neighbour erased", q, 32'hFFFFFFFF);
      bus(0, 0, 6'd0, 0, q, lat);  chk("R3 other sector kept", q, model[0]);

      // restore protection
      bus(1, 1, 6'd1, 32'h07F00000, q, lat);
      bus(1, 0, 6'd1, 0, q, lat); chk("R2 cr restored", q, 32'h07F00000);
      bus(1, 0, 6'd0, 0, sr, lat); chk("R5 all protected", 32'(sr[8:5]), 32'hF);

      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule